// File: doc/BRIEF.md
# Shared Memory Bank Conflict Estimator

The block takes one warp's shared-memory request and works out how many access cycles the banked memory would need. A request carries one word address per lane and an active-lane mask. The warp is divided into equal contiguous parts, and each part is evaluated on its own. Within a part, the block counts how many active lanes hit each bank. It then collapses the duplicates of a single broadcast word and takes the busiest bank as the part's cost. The reported cycle count is the sum of the part costs.

The lanes are walked serially, one lane per clock, in two passes per part. The first pass finds the broadcast word. The second pass finds the busiest bank after the discount. The result is held until it is acknowledged. The block does not touch the banks themselves.

Top module: `smem_conflict_est`

## Requirements
- R1: For a request with at least one active lane, `cycles_o` equals the sum, over all warp parts, of the largest bank total in that part.
- R2: Inactive lanes contribute nothing to any bank total, whatever their addresses.
- R3: In each part exactly one broadcast is applied. It is the first (bank, word) pair with more than one request, found by scanning banks in ascending order and, within a bank, words in ascending address order. That bank's total is reduced by n-1, where n is the pair's request count. All other duplicate words still count in full.
- R4: The warp is split into PARTS equal contiguous parts, and each part is evaluated independently. Part k covers lanes k*LANES/PARTS up to (k+1)*LANES/PARTS-1.
- R5: For any request with at least one active lane, the result lies between 1 and LANES, and `pred_off_o` is 0.
- R6: A request with no active lane finishes with `cycles_o` = 0 and `pred_off_o` = 1. Its `done_o` is visible right after the clock edge that accepts it.
- R7: For a request with at least one active lane, `done_o` rises after the 2*LANES-th clock edge following the accepting edge and is low before that.
- R8: A request is accepted only when the block is idle. `req_valid_i` is ignored while the block is busy or done. `done_o`, `cycles_o` and `pred_off_o` hold until `ack_i` is seen with `done_o`. The block is then idle, and `done_o` is low, from the next cycle.
- R9: The word of a lane is its address with the low log2(WORD_BYTES) bits dropped. With the plain mapping, the bank is that word modulo BANKS. Addresses that differ only in byte offset are the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, taken only when idle |
| req_mask_i | input | LANES | Active-lane mask, bit i for lane i |
| req_addr_i | input | LANES x ADDR_W | Byte address of each lane |
| ack_i | input | 1 | Acknowledge of a held result |
| done_o | output | 1 | Result valid, held until acknowledged |
| cycles_o | output | clog2(LANES+1) | Estimated access cycles |
| pred_off_o | output | 1 | Request had no active lane |

## Verification
The result of an active request is due exactly 2*LANES clock edges after the accepting edge, and an all-inactive result is due right after the accepting edge. The bench drives inputs on falling edges and samples on every falling edge after acceptance. It expects `done_o` low on each sample before the due one and the reference count on the due one. During a run and while a result is held, it pokes fresh requests, which must not change anything. It also checks, cycle by cycle, that the held values stay put until the acknowledge and that `done_o` drops on the next sample.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIND = 2'd1,
        ST_SIZE = 2'd2,
        ST_DONE = 2'd3
    } bcm_state_e;

endpackage

// File: rtl/bcm_bank_map.sv
module bcm_bank_map #(
    parameter int WORD_W = 30,
    parameter int BANKS  = 32,
    parameter int HASH   = 0
) (
    input  logic [WORD_W-1:0]          word_i,
    output logic [$clog2(BANKS)-1:0]   bank_o
);
    localparam int BANK_W = $clog2(BANKS);

    generate
        if (HASH == 0) begin : g_plain
            // bank = word modulo bank count (R9)
            always_comb begin
                bank_o = BANK_W'(word_i % BANKS);
            end
        end else begin : g_fold
            // xor-fold every word bit onto the bank index
            always_comb begin
                bank_o = '0;
                for (int i = 0; i < WORD_W; i++) begin
                    bank_o[i % BANK_W] = bank_o[i % BANK_W] ^ word_i[i];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/bcm_lane_match.sv
module bcm_lane_match #(
    parameter int LANES  = 32,
    parameter int WORD_W = 30,
    parameter int BANK_W = 5,
    parameter int CNT_W  = 6
) (
    input  logic [WORD_W-1:0]             sel_word_i,
    input  logic [BANK_W-1:0]             sel_bank_i,
    input  logic [LANES-1:0][WORD_W-1:0]  words_i,
    input  logic [LANES-1:0][BANK_W-1:0]  banks_i,
    input  logic [LANES-1:0]              elig_i,
    output logic [CNT_W-1:0]              bank_hits_o,
    output logic [CNT_W-1:0]              word_hits_o
);
    always_comb begin
        bank_hits_o = '0;
        word_hits_o = '0;
        for (int j = 0; j < LANES; j++) begin
            if (elig_i[j] && banks_i[j] == sel_bank_i)
                bank_hits_o = bank_hits_o + 1'b1;
            if (elig_i[j] && words_i[j] == sel_word_i)
                word_hits_o = word_hits_o + 1'b1;
        end
    end
endmodule

// File: rtl/smem_conflict_est.sv
module smem_conflict_est
    import bcm_pkg::*;
#(
    parameter int LANES      = 32,
    parameter int BANKS      = 32,
    parameter int WORD_BYTES = 4,
    parameter int PARTS      = 1,
    parameter int ADDR_W     = 32,
    parameter int BANK_HASH  = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid_i,
    input  logic [LANES-1:0]              req_mask_i,
    input  logic [LANES-1:0][ADDR_W-1:0]  req_addr_i,
    input  logic                          ack_i,
    output logic                          done_o,
    output logic [$clog2(LANES+1)-1:0]    cycles_o,
    output logic                          pred_off_o
);
    localparam int OFF_W      = $clog2(WORD_BYTES);
    localparam int WORD_W     = ADDR_W - OFF_W;
    localparam int BANK_W     = $clog2(BANKS);
    localparam int CNT_W      = $clog2(LANES + 1);
    localparam int IDX_W      = $clog2(LANES);
    localparam int PART_LANES = LANES / PARTS;
    localparam int PL_W       = $clog2(PART_LANES);

    typedef struct packed {
        bcm_state_e                      state;
        logic [IDX_W-1:0]                idx;
        logic [LANES-1:0]                mask;
        logic [LANES-1:0][WORD_W-1:0]    word;
        logic                            bc_valid;
        logic [BANK_W-1:0]               bc_bank;
        logic [WORD_W-1:0]               bc_word;
        logic [CNT_W-1:0]                bc_n;
        logic [CNT_W-1:0]                part_max;
        logic [CNT_W-1:0]                total;
        logic                            pred;
    } est_state_t;

    est_state_t r_q, r_d;

    logic [LANES-1:0][BANK_W-1:0] bank_of;
    logic [LANES-1:0]             elig;
    logic [WORD_W-1:0]            cur_word;
    logic [BANK_W-1:0]            cur_bank;
    logic                         cur_act;
    logic [CNT_W-1:0]             bank_hits, word_hits;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_map
            bcm_bank_map #(
                .WORD_W (WORD_W),
                .BANKS  (BANKS),
                .HASH   (BANK_HASH)
            ) u_map (
                .word_i (r_q.word[g]),
                .bank_o (bank_of[g])
            );
        end
    endgenerate

    // lanes that are active and share the cursor lane's part (R2, R4)
    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            elig[j] = r_q.mask[j] &&
                      ((IDX_W'(j) >> PL_W) == (r_q.idx >> PL_W));
        end
        cur_word = r_q.word[r_q.idx];
        cur_bank = bank_of[r_q.idx];
        cur_act  = r_q.mask[r_q.idx];
    end

    bcm_lane_match #(
        .LANES  (LANES),
        .WORD_W (WORD_W),
        .BANK_W (BANK_W),
        .CNT_W  (CNT_W)
    ) u_match (
        .sel_word_i  (cur_word),
        .sel_bank_i  (cur_bank),
        .words_i     (r_q.word),
        .banks_i     (bank_of),
        .elig_i      (elig),
        .bank_hits_o (bank_hits),
        .word_hits_o (word_hits)
    );

    logic             part_end, better;
    logic [CNT_W-1:0] discount, adj, new_max;

    always_comb begin
        r_d      = r_q;
        part_end = &r_q.idx[PL_W-1:0];
        better   = !r_q.bc_valid || (cur_bank < r_q.bc_bank) ||
                   (cur_bank == r_q.bc_bank && cur_word < r_q.bc_word);
        discount = (r_q.bc_valid && cur_bank == r_q.bc_bank) ?
                   (r_q.bc_n - 1'b1) : '0;
        adj      = bank_hits - discount;
        new_max  = (cur_act && adj > r_q.part_max) ? adj : r_q.part_max;

        case (r_q.state)
            ST_IDLE: begin
                if (req_valid_i) begin
                    for (int l = 0; l < LANES; l++)
                        r_d.word[l] = WORD_W'(req_addr_i[l] >> OFF_W);
                    r_d.mask     = req_mask_i;
                    r_d.idx      = '0;
                    r_d.bc_valid = 1'b0;
                    r_d.part_max = '0;
                    r_d.total    = '0;
                    r_d.pred     = (req_mask_i == '0);
                    r_d.state    = (req_mask_i == '0) ? ST_DONE : ST_FIND;
                end
            end
            ST_FIND: begin
                // first pass: lowest (bank, word) pair with duplicates
                if (cur_act && word_hits > 1 && better) begin
                    r_d.bc_valid = 1'b1;
                    r_d.bc_bank  = cur_bank;
                    r_d.bc_word  = cur_word;
                    r_d.bc_n     = word_hits;
                end
                if (part_end) begin
                    r_d.state = ST_SIZE;
                    r_d.idx   = r_q.idx - IDX_W'(PART_LANES - 1);
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_SIZE: begin
                // second pass: busiest bank after the discount
                if (part_end) begin
                    r_d.total    = r_q.total + new_max;
                    r_d.part_max = '0;
                    r_d.bc_valid = 1'b0;
                    if (r_q.idx == IDX_W'(LANES - 1)) begin
                        r_d.state = ST_DONE;
                    end else begin
                        r_d.state = ST_FIND;
                        r_d.idx   = r_q.idx + 1'b1;
                    end
                end else begin
                    r_d.part_max = new_max;
                    r_d.idx      = r_q.idx + 1'b1;
                end
            end
            ST_DONE: begin
                if (ack_i) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done_o     = (r_q.state == ST_DONE);
    assign cycles_o   = r_q.total;
    assign pred_off_o = r_q.pred;

    // R5: bounded result for requests with an active lane
    a_r5_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !pred_off_o) |-> (cycles_o >= 1 && cycles_o <= CNT_W'(LANES)));

    // R6: all-inactive request reports zero
    a_r6_pred_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && pred_off_o) |-> (cycles_o == '0));

    // R6: all-inactive request finishes at once
    a_r6_fast_done: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && req_valid_i && req_mask_i == '0) |=> (done_o && pred_off_o));

    // R8: held result until acknowledge
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ack_i) |=> (done_o && $stable(cycles_o) && $stable(pred_off_o)));

    // R8: acknowledge releases the result
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ack_i) |=> !done_o);

    // R3: a broadcast candidate always has duplicates
    a_r3_bcast_dup: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.bc_valid |-> (r_q.bc_n >= 2));
endmodule

// File: tb/smem_conflict_est_bench.sv
module smem_conflict_est_bench;
    localparam int LANES = 32;
    localparam int BANKS = 32;
    localparam int WB    = 4;
    localparam int PARTS = 2;
    localparam int PL    = LANES / PARTS;
    localparam int CW    = $clog2(LANES + 1);

    logic                        clk = 1'b0;
    logic                        rst_n = 1'b0;
    logic                        req_valid = 1'b0;
    logic [LANES-1:0]            req_mask = '0;
    logic [LANES-1:0][31:0]      req_addr = '0;
    logic                        ack = 1'b0;
    logic                        done;
    logic [CW-1:0]               cycles;
    logic                        pred_off;

    int total_checks = 0;
    int bad_checks   = 0;
    bit finished     = 0;

    always #2.5 clk = ~clk;

    smem_conflict_est #(
        .LANES(LANES), .BANKS(BANKS), .WORD_BYTES(WB), .PARTS(PARTS), .ADDR_W(32)
    ) u_smem_conflict_est (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_mask_i(req_mask),
        .req_addr_i(req_addr), .ack_i(ack), .done_o(done), .cycles_o(cycles),
        .pred_off_o(pred_off)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total_checks++;
        if (!ok) begin
            bad_checks++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    logic [31:0] ta [LANES];
    logic [LANES-1:0] tm;

    // reference: cost from the rules, bank by bank
    function automatic int ref_cost();
        int sum = 0;
        for (int p = 0; p < PARTS; p++) begin
            int bbank = -1;
            int bword = 0;
            int bn = 0;
            int pmax = 0;
            for (int b = 0; b < BANKS && bbank < 0; b++) begin
                for (int i = p*PL; i < (p+1)*PL; i++) begin
                    int w = int'(ta[i] / WB);
                    if (tm[i] && (w % BANKS) == b) begin
                        int d = 0;
                        for (int j = p*PL; j < (p+1)*PL; j++)
                            if (tm[j] && int'(ta[j] / WB) == w) d++;
                        if (d > 1 && (bn == 0 || w < bword)) begin
                            bword = w;
                            bn = d;
                        end
                    end
                end
                if (bn > 0) bbank = b;
            end
            for (int b = 0; b < BANKS; b++) begin
                int t = 0;
                for (int i = p*PL; i < (p+1)*PL; i++)
                    if (tm[i] && (int'(ta[i] / WB) % BANKS) == b) t++;
                if (b == bbank) t = t - (bn - 1);
                if (t > pmax) pmax = t;
            end
            sum += pmax;
        end
        return sum;
    endfunction

    task automatic run(input string req, input bit poke);
        int exp;
        bit any;
        exp = ref_cost();
        any = (tm != '0);
        @(negedge clk);
        req_valid = 1'b1;
        req_mask  = tm;
        for (int i = 0; i < LANES; i++) req_addr[i] = ta[i];
        @(negedge clk);
        req_valid = 1'b0;
        if (!any) begin
            check(done == 1'b1, {req, " R6 done"}, int'(done), 1);
            check(pred_off == 1'b1, {req, " R6 flag"}, int'(pred_off), 1);
            check(cycles == '0, {req, " R6 count"}, int'(cycles), 0);
        end else begin
            for (int k = 1; k <= 2*LANES; k++) begin
                check(done == 1'b0, {req, " R7 early"}, int'(done), 0);
                if (poke && k == 3) begin
                    req_valid = 1'b1;
                    req_mask  = ~tm;
                    for (int i = 0; i < LANES; i++) req_addr[i] = 32'(i * 128);
                end
                @(negedge clk);
                req_valid = 1'b0;
            end
            check(done == 1'b1, {req, " R7 due"}, int'(done), 1);
            check(int'(cycles) == exp, {req, " R1 count"}, int'(cycles), exp);
            check(pred_off == 1'b0, {req, " R5 flag"}, int'(pred_off), 0);
            check(cycles >= 1 && int'(cycles) <= LANES, {req, " R5 range"}, int'(cycles), exp);
        end
        begin
            int held;
            held = int'(cycles);
            for (int k = 0; k < 3; k++) begin
                req_valid = (k == 1);
                req_mask  = '0;
                @(negedge clk);
                req_valid = 1'b0;
                check(done == 1'b1 && int'(cycles) == held, {req, " R8 hold"},
                      int'(cycles), held);
            end
        end
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check(done == 1'b0, {req, " R8 release"}, int'(done), 0);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(done == 1'b0 && cycles == '0 && pred_off == 1'b0, "reset R8", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: distinct banks everywhere -> 1 per part
        for (int i = 0; i < LANES; i++) ta[i] = 32'(i * 4);
        tm = '1;
        run("distinct R1 R4", 1'b1);

        // R3: one word for all lanes -> broadcast per part
        for (int i = 0; i < LANES; i++) ta[i] = 32'h40;
        run("same word R3", 1'b0);

        // R5: every lane in bank 0, distinct words -> upper bound
        for (int i = 0; i < LANES; i++) ta[i] = 32'(i * 128);
        run("bank0 R5 R4", 1'b0);

        // R2: inactive lanes hold conflicting addresses
        tm = 32'h0001_0001;
        run("masked R2", 1'b0);

        // R6: nothing active
        tm = '0;
        run("empty R6", 1'b0);

        // R3: two duplicate words in bank 0, lower one collapsed
        for (int i = 0; i < LANES; i++) ta[i] = 32'(i * 4);
        for (int i = 0; i < 4; i++) ta[i] = 32'h0;
        for (int i = 4; i < 8; i++) ta[i] = 32'd128;
        tm = '1;
        run("two dups R3", 1'b0);

        // R3: broadcast in bank 1 wins, bank 2 duplicates count in full
        for (int i = 0; i < 3; i++) ta[i] = 32'd4;
        for (int i = 3; i < 6; i++) ta[i] = 32'd8;
        for (int i = 6; i < 8; i++) ta[i] = 32'd136;
        tm = 32'h0000_00FF;
        run("bank order R3", 1'b1);

        // R9: byte offsets inside one word
        for (int i = 0; i < LANES; i++) ta[i] = 32'(i * 4);
        for (int i = 0; i < 4; i++) ta[i] = 32'(i);
        tm = '1;
        run("byte offset R9", 1'b0);

        // R1 R2 R3: random patterns over few banks and words
        for (int n = 0; n < 12; n++) begin
            for (int i = 0; i < LANES; i++)
                ta[i] = 32'($urandom_range(0, 3) * 128 + $urandom_range(0, 3) * 4
                            + $urandom_range(0, 3));
            tm = (n == 0) ? '1 : LANES'($urandom);
            run("random R1", n[0]);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end
endmodule